// File: doc/BRIEF.md
# Chip-Select Decoder with Memory-Type Wait States

This block sits between a system bus and a set of external memory banks. For every bus request it compares a window of the address against the select field of each chip select, under a shared mask, and picks the bank that answers. It then holds that bank's chip-select line for as many cycles as that bank needs. The count depends on the bank's memory kind, on the access direction and on fields packed into the bank's timing word. A single-cycle acknowledge closes each access. A request that no enabled bank claims is answered at once with a one-cycle error pulse.

Each bank has one 32-bit configuration word and one 32-bit timing word, which are presented as flat input buses. The block only decides which bank is selected and how long the access takes. Driving the memory pins is left to the neighbouring logic.

Top module: `chipsel_wait_decoder`

## Requirements
- R1: Bank i matches when (addr[29:22] & mask) equals the select field cfg_i[15:8]. Address bits outside [29:22] take no part in the match, and a select field with a bit set outside the mask never matches.
- R2: A bank whose enable bit cfg_i[0] is 0 never matches.
- R3: When several banks match, the bank with the lowest index is selected.
- R4: When no bank matches an accepted request, `err` is high for exactly one cycle, starting at the edge after acceptance. `busy`, `ack` and `cs_sel` stay low.
- R5: The memory kind is cfg_i[2:1]: 0 is SDRAM, 1 is SSRAM, 2 is asynchronous and 3 is synchronous.
- R6: For an asynchronous read the latency L is tim[7:0] + tim[11:8].
- R7: For an asynchronous write the latency L is tim[15:12] + tim[19:16] + tim[25:20].
- R8: For SDRAM, reads and writes both have L = 3 + tim[5:4].
- R9: For SSRAM and for synchronous memory, reads and writes both have L = 2.
- R10: A request is accepted at a rising edge where `req` is high and `busy` is low. `busy` rises at that edge, and `cs_sel` holds the one-hot winner while `busy` is high and is zero otherwise. `ack` rises at the (L+1)-th rising edge after acceptance, at the same edge where `busy` falls, and stays high for one cycle.
- R11: A request raised while `busy` is high is ignored. It changes neither `cs_sel` nor the acknowledge time, and it produces no error.
- R12: After a synchronous reset, `busy`, `ack`, `err` and `cs_sel` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request strobe |
| we | input | 1 | Direction: 1 write, 0 read |
| addr | input | ADDR_W | Bus address |
| mask | input | SEL_W | Global select mask |
| cfg | input | NUM_CS*32 | Per-bank configuration words, bank i at [32i+31:32i] |
| tim | input | NUM_CS*32 | Per-bank timing words, bank i at [32i+31:32i] |
| cs_sel | output | NUM_CS | One-hot chip select of the access in progress |
| busy | output | 1 | Access in progress |
| ack | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for an unclaimed request |

## Verification
The bench builds the block with its defaults: four banks, an 8-bit select window at address bit 22, and 9-bit latency counters. With four banks, the bench can place three banks on one select value to exercise priority, and can combine a disabled bank with a mask that hides or exposes select bits. With 9-bit counters, the longest asynchronous read (270 cycles) and the zero-latency asynchronous case can both be timed edge by edge.

// File: rtl/csdec_pkg.sv
package csdec_pkg;

    localparam int WORD_W   = 32;
    localparam int LAT_W    = 9;
    localparam int EN_BIT   = 0;
    localparam int KIND_LSB = 1;
    localparam int SEL_FLD  = 8;

    typedef enum logic [1:0] {
        MEM_SDRAM = 2'd0,
        MEM_SSRAM = 2'd1,
        MEM_ASYNC = 2'd2,
        MEM_SYNC  = 2'd3
    } mem_kind_e;

    typedef struct packed {
        logic [LAT_W-1:0] lat;
        mem_kind_e        kind;
    } bank_timing_t;

    function automatic mem_kind_e kind_of(input logic [WORD_W-1:0] c);
        return mem_kind_e'(c[KIND_LSB +: 2]);
    endfunction

    function automatic logic [LAT_W-1:0] wait_cycles(input mem_kind_e k,
                                                     input logic we,
                                                     input logic [WORD_W-1:0] t);
        logic [LAT_W-1:0] r;
        case (k)
            MEM_ASYNC: begin
                if (we)
                    r = LAT_W'(t[15:12]) + LAT_W'(t[19:16]) + LAT_W'(t[25:20]);
                else
                    r = LAT_W'(t[7:0]) + LAT_W'(t[11:8]);
            end
            MEM_SDRAM: r = LAT_W'(3) + LAT_W'(t[5:4]);
            default:   r = LAT_W'(2);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cs_match.sv
module cs_match
    import csdec_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int SEL_W   = 8,
    parameter int SEL_POS = 22
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SEL_W-1:0]  mask,
    input  logic [WORD_W-1:0] cfg,
    output logic              hit
);
    logic [SEL_W-1:0] window;
    logic [SEL_W-1:0] sel_fld;

    assign window  = addr[SEL_POS +: SEL_W];
    assign sel_fld = cfg[SEL_FLD +: SEL_W];
    assign hit     = cfg[EN_BIT] && ((window & mask) == sel_fld);
endmodule

// File: rtl/cs_prio.sv
module cs_prio #(
    parameter int N = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     hits,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    always_comb begin
        grant = '0;
        idx   = '0;
        any   = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = IDX_W'(i);
                any      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cs_wait_timer.sv
module cs_wait_timer
    import csdec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LAT_W-1:0] load,
    output logic             busy,
    output logic             done
);
    logic [LAT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy <= 1'b1;
                cnt  <= load;
            end else if (busy) begin
                if (cnt == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    // R10: an access in progress either continues or completes
    a_r10_busy_ends_in_done: assert property (@(posedge clk) disable iff (rst)
        busy && !start |=> busy || done);
    // R10: completion is a single-cycle pulse
    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R10: the count never rises while waiting
    a_r10_cnt_down: assert property (@(posedge clk) disable iff (rst)
        busy && !start && cnt != '0 |=> cnt < $past(cnt));
endmodule

// File: rtl/chipsel_wait_decoder.sv
module chipsel_wait_decoder
    import csdec_pkg::*;
#(
    parameter int NUM_CS  = 4,
    parameter int ADDR_W  = 32,
    parameter int SEL_W   = 8,
    parameter int SEL_POS = 22
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [SEL_W-1:0]         mask,
    input  logic [NUM_CS*WORD_W-1:0] cfg,
    input  logic [NUM_CS*WORD_W-1:0] tim,
    output logic [NUM_CS-1:0]        cs_sel,
    output logic                     busy,
    output logic                     ack,
    output logic                     err
);
    localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

    logic [NUM_CS-1:0] hits;
    logic [NUM_CS-1:0] grant;
    logic [IDX_W-1:0]  win_idx;
    logic              any_hit;
    logic              accept;
    logic              start;
    logic [NUM_CS-1:0] cs_q;
    logic              err_q;
    bank_timing_t      bank_t [NUM_CS];
    bank_timing_t      win_t;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_bank
        cs_match #(
            .ADDR_W (ADDR_W),
            .SEL_W  (SEL_W),
            .SEL_POS(SEL_POS)
        ) u_match (
            .addr(addr),
            .mask(mask),
            .cfg (cfg[g*WORD_W +: WORD_W]),
            .hit (hits[g])
        );
        assign bank_t[g].kind = kind_of(cfg[g*WORD_W +: WORD_W]);
        assign bank_t[g].lat  = wait_cycles(kind_of(cfg[g*WORD_W +: WORD_W]), we,
                                            tim[g*WORD_W +: WORD_W]);
    end

    cs_prio #(.N(NUM_CS)) u_prio (
        .hits (hits),
        .grant(grant),
        .idx  (win_idx),
        .any  (any_hit)
    );

    assign win_t  = bank_t[win_idx];
    assign accept = req && !busy;
    assign start  = accept && any_hit;

    cs_wait_timer u_timer (
        .clk  (clk),
        .rst  (rst),
        .start(start),
        .load (win_t.lat),
        .busy (busy),
        .done (ack)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q  <= '0;
            err_q <= 1'b0;
        end else begin
            err_q <= accept && !any_hit;
            if (start)
                cs_q <= grant;
        end
    end

    assign cs_sel = busy ? cs_q : '0;
    assign err    = err_q;

    // R10: at most one chip select at a time
    a_r10_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cs_sel));
    // R10: a bank is selected throughout an access
    a_r10_sel_while_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> cs_sel != '0);
    // R10: the selection is stable across an access
    a_r10_sel_stable: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) && !$rose(busy) |-> $stable(cs_sel));
    // R4: an error never coincides with an access
    a_r4_err_idle: assert property (@(posedge clk) disable iff (rst)
        err |-> !busy && !ack && cs_sel == '0);
    // R11: an access starts only from an idle block with a request
    a_r11_start_from_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req) && !$past(busy));
    // R10: the acknowledge closes an access
    a_r10_ack_after_busy: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(busy) && !busy);
endmodule

// File: tb/tb_chipsel_wait_decoder.sv
`timescale 1ns/1ps
module tb_chipsel_wait_decoder;
    localparam int NCS = 4;

    logic              clk = 1'b0;
    logic              rst;
    logic              req;
    logic              we;
    logic [31:0]       addr;
    logic [7:0]        mask;
    logic [NCS*32-1:0] cfg;
    logic [NCS*32-1:0] tim;
    logic [NCS-1:0]    cs_sel;
    logic              busy, ack, err;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    chipsel_wait_decoder #(.NUM_CS(NCS), .ADDR_W(32), .SEL_W(8), .SEL_POS(22)) dut (
        .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .mask(mask),
        .cfg(cfg), .tim(tim), .cs_sel(cs_sel), .busy(busy), .ack(ack), .err(err)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_cfg(input bit en, input int kind, input logic [7:0] sel);
        logic [31:0] c;
        c = '0;
        c[0]    = en;
        c[2:1]  = kind[1:0];
        c[15:8] = sel;
        return c;
    endfunction

    function automatic int ref_pick(input logic [31:0] a);
        for (int i = 0; i < NCS; i++) begin
            logic [31:0] c;
            c = cfg[i*32 +: 32];
            if (c[0] && ((a[29:22] & mask) == c[15:8])) return i;
        end
        return -1;
    endfunction

    function automatic int ref_lat(input int i, input bit w);
        logic [31:0] c, t;
        c = cfg[i*32 +: 32];
        t = tim[i*32 +: 32];
        case (c[2:1])
            2'd2:    return w ? int'(t[15:12]) + int'(t[19:16]) + int'(t[25:20])
                              : int'(t[7:0]) + int'(t[11:8]);
            2'd0:    return 3 + int'(t[5:4]);
            default: return 2;
        endcase
    endfunction

    task automatic access(input logic [31:0] a, input bit w, input bit poke, input string tag);
        int ei, n, lat;
        bit seen, hold_ok;
        logic [NCS-1:0] exp_sel;
        ei = ref_pick(a);
        @(negedge clk);
        addr = a; we = w; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        if (ei < 0) begin
            chk(err === 1'b1 && busy === 1'b0 && cs_sel === '0 && ack === 1'b0,
                {tag, " R4 miss gives error"}, err, 1);
            @(negedge clk);
            chk(err === 1'b0 && busy === 1'b0, {tag, " R4 error pulse one cycle"}, err, 0);
            return;
        end
        lat = ref_lat(ei, w);
        exp_sel = NCS'(1) << ei;
        chk(busy === 1'b1 && cs_sel === exp_sel, {tag, " R1 R3 selected bank"}, cs_sel, exp_sel);
        n = 0; seen = 0; hold_ok = 1;
        while (!seen && n < 400) begin
            @(negedge clk);
            n++;
            if (poke && n == 1) begin
                addr = ~a; we = ~w; req = 1'b1;
            end else begin
                req = 1'b0;
            end
            if (ack === 1'b1) seen = 1;
            else if (cs_sel !== exp_sel || busy !== 1'b1 || err !== 1'b0) hold_ok = 0;
        end
        req = 1'b0;
        chk(hold_ok, {tag, " R10 R11 select held, no error"}, hold_ok, 1);
        chk(seen && n == lat + 1, {tag, " R10 ack edge (R6 R7 R8 R9 latency)"}, n, lat + 1);
        chk(busy === 1'b0 && cs_sel === '0, {tag, " R10 idle at ack"}, busy, 0);
        @(negedge clk);
        chk(ack === 1'b0, {tag, " R10 ack single cycle"}, ack, 0);
    endtask

    task automatic rand_cfg();
        mask = 8'($urandom);
        for (int i = 0; i < NCS; i++) begin
            cfg[i*32 +: 32] = mk_cfg(($urandom % 4) != 0, int'($urandom % 4),
                                     8'($urandom) & mask);
            tim[i*32 +: 32] = $urandom;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] a;
        void'($urandom(32'h5EED_C0DE));
        rst = 1'b1; req = 1'b0; we = 1'b0; addr = '0; mask = 8'hFF;
        cfg = '0; tim = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0 && ack === 1'b0 && err === 1'b0 && cs_sel === '0,
            "R12 reset state", {busy, ack, err, cs_sel}, 0);

        // R5 R6 R7: asynchronous bank 0, select 0x05
        mask = 8'hFF;
        cfg[0 +: 32]  = mk_cfg(1, 2, 8'h05);
        tim[0 +: 32]  = {6'd0, 6'd9, 4'd7, 4'd3, 4'd6, 8'd20};
        cfg[32 +: 32] = mk_cfg(1, 0, 8'h11);
        tim[32 +: 32] = 32'h0000_0020;
        cfg[64 +: 32] = mk_cfg(1, 1, 8'h22);
        tim[64 +: 32] = 32'hFFFF_FFFF;
        cfg[96 +: 32] = mk_cfg(1, 3, 8'h33);
        tim[96 +: 32] = 32'hFFFF_FFFF;
        access({2'b11, 8'h05, 22'h1234}, 1'b0, 1'b0, "R6 async read");
        access({2'b00, 8'h05, 22'h0}, 1'b1, 1'b0, "R7 async write");
        access({2'b00, 8'h11, 22'h3FF}, 1'b0, 1'b0, "R8 sdram read");
        access({2'b00, 8'h11, 22'h3FF}, 1'b1, 1'b0, "R8 sdram write");
        access({2'b01, 8'h22, 22'h0}, 1'b0, 1'b0, "R9 ssram");
        access({2'b10, 8'h33, 22'h5}, 1'b1, 1'b0, "R9 sync");
        // R11: request during an access is ignored
        access({2'b00, 8'h05, 22'h7}, 1'b0, 1'b1, "R11 poke during async");
        // R3: banks 1..3 share a select value; lowest enabled wins
        cfg[32 +: 32] = mk_cfg(1, 0, 8'h44);
        cfg[64 +: 32] = mk_cfg(1, 1, 8'h44);
        cfg[96 +: 32] = mk_cfg(1, 3, 8'h44);
        access({2'b00, 8'h44, 22'h0}, 1'b0, 1'b0, "R3 priority bank1");
        cfg[32 +: 32] = mk_cfg(0, 0, 8'h44);
        access({2'b00, 8'h44, 22'h0}, 1'b0, 1'b0, "R2 R3 disabled skipped");
        // R2 R4: only matching bank disabled
        cfg[0 +: 32] = mk_cfg(0, 2, 8'h05);
        access({2'b00, 8'h05, 22'h0}, 1'b0, 1'b0, "R2 disabled bank");
        // R1: mask hides low window bits
        mask = 8'hF0;
        cfg[0 +: 32] = mk_cfg(1, 1, 8'h30);
        access({2'b00, 8'h3A, 22'h0}, 1'b0, 1'b0, "R1 masked match");
        cfg[0 +: 32] = mk_cfg(1, 1, 8'h31);
        cfg[32 +: 32] = '0; cfg[64 +: 32] = '0; cfg[96 +: 32] = '0;
        access({2'b00, 8'h31, 22'h0}, 1'b0, 1'b0, "R1 unmaskable select miss");
        // R10: zero-latency asynchronous access
        mask = 8'hFF;
        cfg[0 +: 32] = mk_cfg(1, 2, 8'h00);
        tim[0 +: 32] = 32'h0;
        access(32'h0, 1'b0, 1'b0, "R10 zero latency");
        // R6: longest asynchronous read
        tim[0 +: 32] = 32'h0000_0FFF;
        access(32'hC000_0000, 1'b0, 1'b0, "R6 max read");

        for (int k = 0; k < 160; k++) begin
            int j;
            if (k % 8 == 0) rand_cfg();
            a = $urandom;
            if ($urandom % 4 != 0) begin
                j = int'($urandom % NCS);
                a[29:22] = cfg[j*32 + 8 +: 8] | (8'($urandom) & ~mask);
            end
            access(a, 1'($urandom), ($urandom % 3) == 0, "R1 R5 random");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule